// File: doc/BRIEF.md
# Indirect Register Pointer Unit

This block gives an instruction pipeline two indirection pointers into a 512-word register file. Two register addresses are reserved, one per pointer. When the decoded destination (D) or source (S) operand field of an instruction carries one of them, the block puts the pointer's current value on the effective address output in its place. Any other operand address passes through unchanged. The register file and the decoder sit outside the block. The block only rewrites the two operand addresses and keeps the pointer state.

Each pointer has its own bottom and top bound. It moves only inside that window. It can be moved after an access, by one step up or down, or by a signed delta command. A step past either bound wraps to the opposite bound. A set command loads both bounds from immediate values. A start pulse sends each pointer back to its own reserved address, with a window one entry wide. In that state the reserved locations behave as ordinary registers. A pointer can also be aimed at a reserved address. That is the only way to reach the storage that stays hidden behind it, because no substitution is chained.

Top module: `ind_ptr_unit`

## Requirements
- R1: When an operand field equals neither 0x1F6 nor 0x1F7, its effective address output (`d_eff` for D, `s_eff` for S) equals the field in the same cycle.
- R2: A field value of 0x1F6 yields the current value of pointer A, and 0x1F7 yields pointer B. The value is the one held before this cycle's update. A command aimed at one pointer leaves the other unchanged.
- R3: After reset, and one cycle after a `start` pulse, pointer A holds 0x1F6 and pointer B holds 0x1F7, each with bottom = top = its own address. Stepping in that state leaves the pointer where it is.
- R4: `set_en` with `set_sel` (0 = A, 1 = B) loads top = `set_top` and bottom = `set_bot`, and places the pointer at the bottom. The new value is visible from the next cycle.
- R5: Operand post-modify codes are 2'b01 = increment and 2'b10 = decrement. Codes 2'b00 and 2'b11 mean no change. The move applies after the access. Incrementing at top wraps to bottom, and decrementing at bottom wraps to top.
- R6: `delta_en` with `delta_sel` adds `delta_val`, a 9-bit two's-complement value, to the selected pointer. For a magnitude no larger than the window size, a result above top or below bottom wraps by one window size.
- R7: When the same pointer is named in both D and S of one instruction, it moves only once. The D code is used if it is a move code. Otherwise the S code is used.
- R8: A pointer aimed at 0x1F6 or 0x1F7 yields that raw address. It is not substituted a second time.
- R9: A set command whose bottom is above its top has no effect on the pointer or its bounds.
- R10: For one pointer in one cycle, the priority is start, then a valid set, then delta, then operand post-modify.
- R11: With `op_valid` low, the post-modify codes move no pointer. Substitution still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Returns both pointers to their home state |
| op_valid | input | 1 | Instruction executes this cycle; enables post-modify |
| d_field | input | 9 | Decoded D operand address |
| d_mode | input | 2 | D post-modify code |
| s_field | input | 9 | Decoded S operand address |
| s_mode | input | 2 | S post-modify code |
| set_en | input | 1 | Load bounds of one pointer |
| set_sel | input | 1 | Pointer chosen by set (0 = A, 1 = B) |
| set_top | input | 9 | Immediate top bound |
| set_bot | input | 9 | Immediate bottom bound |
| delta_en | input | 1 | Apply signed delta to one pointer |
| delta_sel | input | 1 | Pointer chosen by delta (0 = A, 1 = B) |
| delta_val | input | 9 | Signed delta, two's complement |
| d_eff | output | 9 | Effective D register address |
| s_eff | output | 9 | Effective S register address |

## Verification
A wrong pointer value or bound appears at the ports the next time the pointer's reserved address is placed in an operand field. There it shows as a wrong `d_eff` or `s_eff` in that same cycle. A bad wrap or a double update therefore shows up one cycle after the step that caused it, provided the bench reads the pointer back at once. The bench does this after every command. The bench sweeps every operand address and every delta across a small window against an arithmetic model.

// File: rtl/ip_pkg.sv
package ip_pkg;
  typedef enum logic [1:0] {
    PM_NONE = 2'b00,
    PM_INC  = 2'b01,
    PM_DEC  = 2'b10,
    PM_RSV  = 2'b11
  } pmod_e;
endpackage

// File: rtl/ip_step.sv
module ip_step #(
  parameter int AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     cur,
  input  logic [AW-1:0]     bot,
  input  logic [AW-1:0]     top,
  input  logic signed [AW:0] step,
  output logic [AW-1:0]     nxt
);
  localparam int W = AW + 2;
  localparam logic signed [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic signed [W-1:0] p_s, b_s, t_s, size_s, sum_s, res_s;

  always_comb begin
    p_s    = $signed({2'b00, cur});
    b_s    = $signed({2'b00, bot});
    t_s    = $signed({2'b00, top});
    size_s = t_s - b_s + ONE;
    sum_s  = p_s + $signed({step[AW], step});
    if (sum_s > t_s)      res_s = sum_s - size_s;
    else if (sum_s < b_s) res_s = sum_s + size_s;
    else                  res_s = sum_s;
    nxt = res_s[AW-1:0];
  end

  // R6
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur >= bot && cur <= top) |-> (res_s >= b_s && res_s <= t_s));
endmodule

// File: rtl/ip_ptr.sv
module ip_ptr #(
  parameter int AW = 9,
  parameter logic [AW-1:0] HOME = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               load,
  input  logic [AW-1:0]      ld_top,
  input  logic [AW-1:0]      ld_bot,
  input  logic               upd,
  input  logic signed [AW:0] step,
  output logic [AW-1:0]      ptr,
  output logic [AW-1:0]      bot,
  output logic [AW-1:0]      top
);
  logic [AW-1:0] ptr_q, bot_q, top_q;
  logic [AW-1:0] ptr_d, bot_d, top_d;
  logic [AW-1:0] stepped;
  logic          load_ok, en;

  assign load_ok = load && (ld_bot <= ld_top);
  assign en      = start || load_ok || upd;

  ip_step #(.AW(AW)) u_step (
    .clk  (clk),
    .rst_n(rst_n),
    .cur  (ptr_q),
    .bot  (bot_q),
    .top  (top_q),
    .step (step),
    .nxt  (stepped)
  );

  always_comb begin
    ptr_d = ptr_q;
    bot_d = bot_q;
    top_d = top_q;
    if (start) begin
      ptr_d = HOME;
      bot_d = HOME;
      top_d = HOME;
    end else if (load_ok) begin
      ptr_d = ld_bot;
      bot_d = ld_bot;
      top_d = ld_top;
    end else if (upd) begin
      ptr_d = stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= HOME;
      bot_q <= HOME;
      top_q <= HOME;
    end else if (en) begin
      ptr_q <= ptr_d;
      bot_q <= bot_d;
      top_q <= top_d;
    end
  end

  assign ptr = ptr_q;
  assign bot = bot_q;
  assign top = top_q;

  // R5
  window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q >= bot_q && ptr_q <= top_q);

  // R9
  bound_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bot_q <= top_q);

  // R3
  start_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ptr_q == HOME && bot_q == HOME && top_q == HOME));

  // R5
  inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !start && !load_ok && step == 1 && ptr_q == top_q) |=> ptr_q == $past(bot_q));

  // R11
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start || load || upd) |=> $stable(ptr_q));
endmodule

// File: rtl/ip_subst.sv
module ip_subst #(
  parameter int AW = 9,
  parameter logic [AW-1:0] A_ADDR = '0,
  parameter logic [AW-1:0] B_ADDR = '0
) (
  input  logic [AW-1:0] field,
  input  logic [AW-1:0] ptr_a,
  input  logic [AW-1:0] ptr_b,
  output logic [AW-1:0] eff
);
  always_comb begin
    if (field == A_ADDR)      eff = ptr_a;
    else if (field == B_ADDR) eff = ptr_b;
    else                      eff = field;
  end
endmodule

// File: rtl/ind_ptr_unit.sv
module ind_ptr_unit #(
  parameter int AW = 9,
  parameter logic [AW-1:0] PTR_A_ADDR = 9'h1F6,
  parameter logic [AW-1:0] PTR_B_ADDR = 9'h1F7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_valid,
  input  logic [AW-1:0] d_field,
  input  logic [1:0]    d_mode,
  input  logic [AW-1:0] s_field,
  input  logic [1:0]    s_mode,
  input  logic          set_en,
  input  logic          set_sel,
  input  logic [AW-1:0] set_top,
  input  logic [AW-1:0] set_bot,
  input  logic          delta_en,
  input  logic          delta_sel,
  input  logic [AW-1:0] delta_val,
  output logic [AW-1:0] d_eff,
  output logic [AW-1:0] s_eff
);
  import ip_pkg::*;

  localparam int NPTR = 2;

  logic [1:0] rst_sync;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  logic [AW-1:0] ptr_q [NPTR];
  logic [AW-1:0] bot_q [NPTR];
  logic [AW-1:0] top_q [NPTR];

  pmod_e d_m, s_m;
  logic  d_moves, s_moves;
  assign d_m     = pmod_e'(d_mode);
  assign s_m     = pmod_e'(s_mode);
  assign d_moves = (d_m == PM_INC) || (d_m == PM_DEC);
  assign s_moves = (s_m == PM_INC) || (s_m == PM_DEC);

  function automatic logic signed [AW:0] mode_step(input pmod_e m);
    if (m == PM_DEC) return '1;
    return (AW+1)'(1);
  endfunction

  for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
    localparam logic [AW-1:0] HOME = (gi == 0) ? PTR_A_ADDR : PTR_B_ADDR;
    logic               set_hit, dlt_hit, d_use, s_use, upd;
    logic signed [AW:0] stp;

    assign set_hit = set_en && (set_sel == 1'(gi));
    assign dlt_hit = delta_en && (delta_sel == 1'(gi));
    assign d_use   = op_valid && (d_field == HOME) && d_moves;
    assign s_use   = op_valid && (s_field == HOME) && s_moves;

    always_comb begin
      stp = '0;
      upd = 1'b0;
      if (dlt_hit) begin
        stp = {delta_val[AW-1], delta_val};
        upd = 1'b1;
      end else if (d_use) begin
        stp = mode_step(d_m);
        upd = 1'b1;
      end else if (s_use) begin
        stp = mode_step(s_m);
        upd = 1'b1;
      end
    end

    ip_ptr #(.AW(AW), .HOME(HOME)) u_ptr (
      .clk   (clk),
      .rst_n (rst_s_n),
      .start (start),
      .load  (set_hit),
      .ld_top(set_top),
      .ld_bot(set_bot),
      .upd   (upd),
      .step  (stp),
      .ptr   (ptr_q[gi]),
      .bot   (bot_q[gi]),
      .top   (top_q[gi])
    );
  end

  ip_subst #(.AW(AW), .A_ADDR(PTR_A_ADDR), .B_ADDR(PTR_B_ADDR)) u_sub_d (
    .field(d_field), .ptr_a(ptr_q[0]), .ptr_b(ptr_q[1]), .eff(d_eff)
  );

  ip_subst #(.AW(AW), .A_ADDR(PTR_A_ADDR), .B_ADDR(PTR_B_ADDR)) u_sub_s (
    .field(s_field), .ptr_a(ptr_q[0]), .ptr_b(ptr_q[1]), .eff(s_eff)
  );

  // R1
  pass_d_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (d_field != PTR_A_ADDR && d_field != PTR_B_ADDR) |-> d_eff == d_field);

  // R1
  pass_s_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (s_field != PTR_A_ADDR && s_field != PTR_B_ADDR) |-> s_eff == s_field);

  // R2
  other_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!start && !op_valid && set_en && delta_en && set_sel == 1'b0 && delta_sel == 1'b0)
      |=> $stable(ptr_q[1]));
endmodule

// File: tb/sim_ind_ptr_unit.sv
module sim_ind_ptr_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, op_valid, set_en, set_sel, delta_en, delta_sel;
  logic [8:0] d_field, s_field, set_top, set_bot, delta_val;
  logic [1:0] d_mode, s_mode;
  logic [8:0] d_eff, s_eff;

  int errors = 0;
  int checks = 0;
  int mp [2];
  int mb [2];
  int mt [2];
  int cyc = 0;

  localparam int ADR_A = 'h1F6;
  localparam int ADR_B = 'h1F7;

  always #4 clk = ~clk;

  ind_ptr_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_valid(op_valid),
    .d_field(d_field), .d_mode(d_mode), .s_field(s_field), .s_mode(s_mode),
    .set_en(set_en), .set_sel(set_sel), .set_top(set_top), .set_bot(set_bot),
    .delta_en(delta_en), .delta_sel(delta_sel), .delta_val(delta_val),
    .d_eff(d_eff), .s_eff(s_eff)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int addr_of(input int i);
    return (i == 0) ? ADR_A : ADR_B;
  endfunction

  function automatic int subst(input int f);
    if (f == ADR_A) return mp[0];
    if (f == ADR_B) return mp[1];
    return f;
  endfunction

  function automatic int mstep(input int i, input int st);
    int s = mp[i] + st;
    int sz = mt[i] - mb[i] + 1;
    if (s > mt[i]) s -= sz;
    else if (s < mb[i]) s += sz;
    return s;
  endfunction

  function automatic int mode_delta(input int m);
    if (m == 1) return 1;
    if (m == 2) return -1;
    return 0;
  endfunction

  task automatic home_model();
    mp[0] = ADR_A; mb[0] = ADR_A; mt[0] = ADR_A;
    mp[1] = ADR_B; mb[1] = ADR_B; mt[1] = ADR_B;
  endtask

  task automatic idle();
    start = 0; op_valid = 0; d_field = 0; d_mode = 0; s_field = 0; s_mode = 0;
    set_en = 0; set_sel = 0; set_top = 0; set_bot = 0;
    delta_en = 0; delta_sel = 0; delta_val = 0;
  endtask

  task automatic drive(input string req, input int strt, input int ov,
                       input int d, input int dm, input int s, input int sm,
                       input int se, input int ssel, input int st, input int sb,
                       input int de, input int dsel, input int dv);
    @(negedge clk);
    start = strt[0]; op_valid = ov[0];
    d_field = 9'(d); d_mode = 2'(dm); s_field = 9'(s); s_mode = 2'(sm);
    set_en = se[0]; set_sel = ssel[0]; set_top = 9'(st); set_bot = 9'(sb);
    delta_en = de[0]; delta_sel = dsel[0]; delta_val = 9'(dv);
    #1;
    check({req, " R2 d_eff"}, int'(d_eff), subst(d));
    check({req, " R2 s_eff"}, int'(s_eff), subst(s));
    for (int i = 0; i < 2; i++) begin
      if (strt != 0) begin
        mp[i] = addr_of(i); mb[i] = addr_of(i); mt[i] = addr_of(i);
      end else if (se != 0 && ssel == i && sb <= st) begin
        mp[i] = sb; mb[i] = sb; mt[i] = st;
      end else if (de != 0 && dsel == i) begin
        mp[i] = mstep(i, dv);
      end else if (ov != 0 && d == addr_of(i) && mode_delta(dm) != 0) begin
        mp[i] = mstep(i, mode_delta(dm));
      end else if (ov != 0 && s == addr_of(i) && mode_delta(sm) != 0) begin
        mp[i] = mstep(i, mode_delta(sm));
      end
    end
    @(posedge clk);
    #1 idle();
  endtask

  task automatic use_op(input string req, input int ov, input int d, input int dm,
                        input int s, input int sm);
    drive(req, 0, ov, d, dm, s, sm, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic set_cmd(input string req, input int sel, input int st, input int sb);
    drive(req, 0, 0, 0, 0, 0, 0, 1, sel, st, sb, 0, 0, 0);
  endtask

  task automatic delta_cmd(input string req, input int sel, input int dv);
    drive(req, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, sel, dv);
  endtask

  task automatic check_ptrs(input string req);
    @(negedge clk);
    d_field = 9'(ADR_A); s_field = 9'(ADR_B); op_valid = 0;
    #1;
    check({req, " ptr A"}, int'(d_eff), mp[0]);
    check({req, " ptr B"}, int'(s_eff), mp[1]);
    idle();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    idle();
    rst_n = 0;
    home_model();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    #1;

    // R3 reset state
    check_ptrs("R3 reset");

    // R1 / R2: sweep of every operand address
    for (int a = 0; a < 512; a++) begin
      @(negedge clk);
      op_valid = 1; d_field = 9'(a); s_field = 9'(511 - a);
      #1;
      check("R1 d pass/subst", int'(d_eff), subst(a));
      check("R1 s pass/subst", int'(s_eff), subst(511 - a));
    end
    idle();

    // R3 stepping in home state stays put
    use_op("R3", 1, ADR_A, 1, ADR_B, 2);
    check_ptrs("R3 home step");

    // R4 set commands
    set_cmd("R4", 0, 'h10, 'h08);
    check_ptrs("R4 set A");
    set_cmd("R4", 1, 'h23, 'h20);
    check_ptrs("R4 set B");

    // R5 increment sweep with wraps on A through D
    for (int k = 0; k < 20; k++) begin
      use_op("R5 inc", 1, ADR_A, 1, 'h005, 0);
      check_ptrs("R5 inc wrap");
    end
    // R5 decrement sweep with wraps on B through S
    for (int k = 0; k < 10; k++) begin
      use_op("R5 dec", 1, 'h033, 0, ADR_B, 2);
      check_ptrs("R5 dec wrap");
    end
    // R5 code 2'b11 is no move
    use_op("R5 rsv", 1, ADR_A, 3, ADR_B, 3);
    check_ptrs("R5 code 11");

    // R6 delta sweep
    for (int r = 0; r < 2; r++)
      for (int dv = -9; dv <= 9; dv++) begin
        delta_cmd("R6", 0, dv);
        check_ptrs("R6 delta A");
      end
    for (int dv = -4; dv <= 4; dv++) begin
      delta_cmd("R6", 1, dv);
      check_ptrs("R6 delta B");
    end

    // R7 same pointer in both fields
    use_op("R7", 1, ADR_A, 1, ADR_A, 1);
    check_ptrs("R7 inc/inc once");
    use_op("R7", 1, ADR_A, 1, ADR_A, 2);
    check_ptrs("R7 D wins");
    use_op("R7", 1, ADR_B, 0, ADR_B, 2);
    check_ptrs("R7 S used");

    // R11 op_valid low
    use_op("R11", 0, ADR_A, 1, ADR_B, 2);
    check_ptrs("R11 no move");

    // R10 priorities
    drive("R10", 0, 0, 0, 0, 0, 0, 1, 0, 'h40, 'h3C, 1, 0, 2);
    check_ptrs("R10 set over delta");
    drive("R10", 0, 1, ADR_B, 1, 0, 0, 0, 0, 0, 0, 1, 1, 3);
    check_ptrs("R10 delta over use");
    drive("R10", 1, 1, ADR_A, 1, 0, 0, 1, 1, 'h50, 'h48, 1, 0, 1);
    check_ptrs("R10 start over all");

    // R9 bad set ignored
    set_cmd("R4", 0, 'h18, 'h11);
    set_cmd("R9", 0, 'h20, 'h30);
    check_ptrs("R9 bad set");
    use_op("R9", 1, ADR_A, 1, 0, 0);
    check_ptrs("R9 bounds kept");

    // R8 pointer aimed at reserved addresses
    set_cmd("R8", 1, 'h27, 'h21);
    set_cmd("R8", 0, ADR_B, ADR_B);
    check_ptrs("R8 A at 1F7");
    set_cmd("R8", 1, ADR_A, ADR_A);
    check_ptrs("R8 B at 1F6");

    // R3 start mid-run
    set_cmd("R4", 0, 'h100, 'h0F0);
    drive("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check_ptrs("R3 start");
    check("R3 A home", mp[0], ADR_A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule